// File: doc/BRIEF.md
# Multi-Lane TDM Slot Mask Allocator

This block turns a requested channel count into one active-slot enable mask per lane of a multi-lane TDM audio port. Each lane carries 32 slot positions and comes with a 32-bit mask of the slots it is permitted to use. Channels are handed out in the order the serializer itself places samples. The allocator works through slot pairs (0/1, then 2/3, and so on up to 30/31). For each pair it visits the lanes from lowest to highest, and within a lane it offers the even slot before the odd one. Because of this order, a given channel index always lands on the same lane and slot, whatever the total channel count of the stream.

A job starts with a one-cycle `start` while the block is idle. The count and the allowed masks are captured on that edge. The block then handles one slot pair across all lanes per clock. It stops as soon as every channel has a slot, or after pair 15. When it finishes, `done` pulses for one cycle. The new masks and the error flag appear together in that same cycle and are held until the next job finishes. If the allowed slots cannot hold every channel, `error` is raised. The partially filled masks are still published, but they must not be used while `error` is high.

Top module: `tdm_slot_alloc`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0 and every bit of `lane_mask` is 0.
- R2: A `start` seen while `busy` is 0 begins a job, and `busy` is 1 from the next cycle. A `start` seen while `busy` is 1 is ignored: the running job's result is unchanged and no extra job follows.
- R3: Slots are granted in this order: pair index p from 0 to 15, then lanes ascending (lane L occupies bits L*32+31 down to L*32 of the flat masks), then slot 2p before slot 2p+1.
- R4: A slot is granted only if its bit is set in that lane's captured allowed mask.
- R5: Granting stops once the requested count has been granted. On success, the number of set bits across all lanes equals the requested count, and no slot later in the R3 order is set.
- R6: If the allowed slots number fewer than the requested count, `error` is 1 at completion and every allowed slot is set in the published masks.
- R7: `done` is high for exactly one cycle per accepted job, never together with `busy`. `error` is valid in that same cycle.
- R8: `lane_mask` and `error` change only in a cycle where `done` is 1.
- R9: `done` rises P cycles after the edge that accepts `start`, where P is the number of slot pairs visited: the index of the pair in which the count reached zero plus one, or 16 on error. A count of 0 gives P = 1.
- R10: With lanes 0 and 1 each allowing slots 0 to 3 and the other lanes allowing none, channel 2 occupies lane 1 slot 0 for both a 4-channel and an 8-channel request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (accepted only when idle) |
| chan_count | input | CNT_W | Number of channels to place |
| allow_mask | input | LANES*32 | Allowed slots, lane L in bits L*32+31:L*32 |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Channels left unplaced at completion |
| lane_mask | output | LANES*32 | Published slot enables, same layout as allow_mask |

## Verification
Several situations are hard to reach from the ports. One is an ignored start: a second request with a different count and masks has to arrive during the few cycles a short job is busy. The bench forces this by holding `start` high on the cycle right after acceptance, and the result must match the first request alone. A second is the order in which the count runs out partway through a pair or a lane, which only shows up with sparse, irregular allowed masks. Pseudo-random masks and counts reach it, and are compared against a reference model of the pair-sweep order. A third is the error path, which needs requests larger than the allowed population. Both exact fill and overflow are driven, so the error flag, the full-sweep latency and the fully set partial masks can all be checked.

// File: rtl/tdm_alloc_pkg.sv
package tdm_alloc_pkg;
    localparam int SLOTS  = 32;
    localparam int PAIRS  = SLOTS / 2;
    localparam int PAIR_W = $clog2(PAIRS);

    typedef logic [SLOTS-1:0] slot_mask_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } alloc_state_e;

    typedef struct packed {
        logic load;
        logic step;
        logic finish;
    } alloc_cmd_t;

    function automatic int count_width(input int lanes);
        return $clog2(SLOTS * lanes + 1);
    endfunction

    function automatic logic [PAIR_W:0] slot_of(input logic [PAIR_W-1:0] pair, input logic odd);
        return {pair, odd};
    endfunction
endpackage

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
    import tdm_alloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rem_zero,
    output alloc_cmd_t        cmd,
    output logic [PAIR_W-1:0] pair_idx,
    output logic              busy,
    output logic              done,
    output logic              error
);
    alloc_state_e state_q;
    logic         last_pair;

    assign last_pair  = (pair_idx == PAIR_W'(PAIRS - 1));
    assign cmd.load   = (state_q == ST_IDLE) && start;
    assign cmd.step   = (state_q == ST_RUN);
    assign cmd.finish = cmd.step && (rem_zero || last_pair);
    assign busy       = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pair_idx <= '0;
            done     <= 1'b0;
            error    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd.load) begin
                        state_q  <= ST_RUN;
                        pair_idx <= '0;
                    end
                end
                ST_RUN: begin
                    pair_idx <= pair_idx + 1'b1;
                    if (cmd.finish) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                        error   <= !rem_zero;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pair_grant.sv
module pair_grant
    import tdm_alloc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input  logic [PAIR_W-1:0]            pair_idx,
    input  logic [LANES-1:0][SLOTS-1:0]  allow,
    input  logic [CNT_W-1:0]             rem_in,
    output logic [LANES-1:0][1:0]        grant,
    output logic [CNT_W-1:0]             rem_out
);
    localparam int TAPS = 2 * LANES;

    logic [CNT_W-1:0] rem_chain [TAPS+1];

    assign rem_chain[0] = rem_in;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar k = 0; k < 2; k++) begin : g_half
            localparam int TAP = 2 * l + k;
            logic [PAIR_W:0] sidx;
            logic            avail;
            assign sidx  = slot_of(pair_idx, 1'(k));
            assign avail = allow[l][sidx];
            assign grant[l][k] = avail && (rem_chain[TAP] != '0);
            assign rem_chain[TAP+1] = rem_chain[TAP] - CNT_W'(grant[l][k]);
        end
    end

    assign rem_out = rem_chain[TAPS];
endmodule

// File: rtl/mask_bank.sv
module mask_bank
    import tdm_alloc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  alloc_cmd_t                   cmd,
    input  logic [PAIR_W-1:0]            pair_idx,
    input  logic [LANES-1:0][1:0]        grant,
    output logic [LANES-1:0][SLOTS-1:0]  pub_mask
);
    for (genvar l = 0; l < LANES; l++) begin : g_bank
        slot_mask_t work_q;
        slot_mask_t work_d;
        slot_mask_t hit;

        always_comb begin
            hit = '0;
            hit[slot_of(pair_idx, 1'b0)] = grant[l][0];
            hit[slot_of(pair_idx, 1'b1)] = grant[l][1];
            work_d = work_q | (cmd.step ? hit : '0);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                work_q      <= '0;
                pub_mask[l] <= '0;
            end else begin
                if (cmd.load)
                    work_q <= '0;
                else if (cmd.step)
                    work_q <= work_d;
                if (cmd.finish)
                    pub_mask[l] <= work_d;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_alloc.sv
module tdm_slot_alloc
    import tdm_alloc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = count_width(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [CNT_W-1:0]       chan_count,
    input  logic [LANES*SLOTS-1:0] allow_mask,
    output logic                   busy,
    output logic                   done,
    output logic                   error,
    output logic [LANES*SLOTS-1:0] lane_mask
);
    alloc_cmd_t                  cmd;
    logic [PAIR_W-1:0]           pair_idx;
    logic [LANES-1:0][SLOTS-1:0] allow_q;
    logic [LANES-1:0][SLOTS-1:0] pub;
    logic [LANES-1:0][1:0]       grant;
    logic [CNT_W-1:0]            rem_q;
    logic [CNT_W-1:0]            rem_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            allow_q <= '0;
            rem_q   <= '0;
        end else if (cmd.load) begin
            allow_q <= allow_mask;
            rem_q   <= chan_count;
        end else if (cmd.step) begin
            rem_q   <= rem_next;
        end
    end

    alloc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rem_zero (rem_next == '0),
        .cmd      (cmd),
        .pair_idx (pair_idx),
        .busy     (busy),
        .done     (done),
        .error    (error)
    );

    pair_grant #(.LANES(LANES), .CNT_W(CNT_W)) u_grant (
        .pair_idx (pair_idx),
        .allow    (allow_q),
        .rem_in   (rem_q),
        .grant    (grant),
        .rem_out  (rem_next)
    );

    mask_bank #(.LANES(LANES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .pair_idx (pair_idx),
        .grant    (grant),
        .pub_mask (pub)
    );

    assign lane_mask = pub;
endmodule

// File: rtl/tdm_slot_alloc_chk.sv
module tdm_slot_alloc_chk #(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [CNT_W-1:0]    chan_count,
    input logic [LANES*32-1:0] allow_mask,
    input logic                busy,
    input logic                done,
    input logic                error,
    input logic [LANES*32-1:0] lane_mask
);
    logic [LANES*32-1:0] cap_allow;
    logic [CNT_W-1:0]    cap_cnt;
    logic [5:0]          run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_allow <= '0;
            cap_cnt   <= '0;
            run_cnt   <= '0;
        end else begin
            if (start && !busy) begin
                cap_allow <= allow_mask;
                cap_cnt   <= chan_count;
            end
            run_cnt <= busy ? run_cnt + 1'b1 : '0;
        end
    end

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    assert_subset_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> ((lane_mask & ~cap_allow) == '0));
    assert_count_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> ($countones(lane_mask) == int'(cap_cnt)));
    assert_error_flag_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (error == (int'(cap_cnt) > $countones(cap_allow))));
    assert_error_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (done && error) |-> (lane_mask == cap_allow));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(lane_mask) && $stable(error)));
    assert_run_bound_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < 6'd16));
endmodule

bind tdm_slot_alloc tdm_slot_alloc_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .chan_count (chan_count),
    .allow_mask (allow_mask),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .lane_mask  (lane_mask)
);

// File: tb/sim_tdm_slot_alloc.sv
`timescale 1ns/1ps
module sim_tdm_slot_alloc;
    localparam int NL = 4;
    localparam int CW = 8;
    localparam int MW = NL * 32;

    typedef struct {
        logic [MW-1:0] mask;
        bit            err;
        longint        cyc;
        string         tag;
    } exp_t;

    logic          clk = 0;
    logic          rst = 1;
    logic          start = 0;
    logic [CW-1:0] chan_count = '0;
    logic [MW-1:0] allow_mask = '0;
    logic          busy, done, error;
    logic [MW-1:0] lane_mask;

    exp_t          sb[$];
    logic [MW-1:0] last_pub = '0;
    bit            last_err = 0;
    longint        cyc = 0;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            ended = 0;
    logic [31:0]   seed = 32'h1234_5679;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tdm_slot_alloc #(.LANES(NL), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .chan_count(chan_count),
        .allow_mask(allow_mask), .busy(busy), .done(done), .error(error),
        .lane_mask(lane_mask)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [MW-1:0] act, input logic [MW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void model(input int cnt, input logic [MW-1:0] al,
                                  output logic [MW-1:0] m, output bit err,
                                  output int pairs);
        m = '0;
        pairs = 0;
        for (int p = 0; p < 16; p++) begin
            pairs = p + 1;
            for (int l = 0; l < NL; l++)
                for (int k = 0; k < 2; k++)
                    if (al[l*32 + 2*p + k] && cnt > 0) begin
                        m[l*32 + 2*p + k] = 1'b1;
                        cnt--;
                    end
            if (cnt == 0) break;
        end
        err = (cnt > 0);
    endfunction

    function automatic logic [31:0] rnd32();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic run_job(input int cnt, input logic [MW-1:0] al, input string tag,
                           input bit intrude);
        exp_t e;
        int   pairs;
        while (busy) @(negedge clk);
        model(cnt, al, e.mask, e.err, pairs);
        e.tag = tag;
        e.cyc = cyc + 1 + pairs;
        sb.push_back(e);
        start = 1; chan_count = CW'(cnt); allow_mask = al;
        @(negedge clk);
        if (intrude) begin
            chan_count = CW'(cnt + 3); allow_mask = ~al;
            @(negedge clk);
        end
        start = 0; allow_mask = '0; chan_count = '0;
    endtask

    task automatic drain();
        while (sb.size() != 0 || busy) @(negedge clk);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && !ended) begin
            if (done) begin
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected done", MW'(1), MW'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(lane_mask == e.mask, "R3", {e.tag, " masks"}, lane_mask, e.mask);
                    check(error == e.err, "R6", {e.tag, " error"}, MW'(error), MW'(e.err));
                    check(cyc == e.cyc, "R9", {e.tag, " latency"}, MW'(cyc), MW'(e.cyc));
                    check(!busy, "R7", {e.tag, " busy at done"}, MW'(busy), MW'(0));
                    last_pub = e.mask;
                    last_err = e.err;
                end
            end else begin
                check(lane_mask == last_pub && error == last_err, "R8", "hold",
                      lane_mask, last_pub);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [MW-1:0] al;
        repeat (3) @(negedge clk);
        check(lane_mask == '0, "R1", "reset masks", lane_mask, '0);
        check({busy, done, error} == 3'b000, "R1", "reset flags",
              MW'({busy, done, error}), '0);
        rst = 0;
        @(negedge clk);

        // R3/R5: all slots allowed, 8 channels -> slots 0,1 of every lane
        run_job(8, '1, "R3 full8", 0);
        // R5: odd count stops mid-pair
        run_job(11, '1, "R5 odd11", 0);
        // R5 / R9: zero count
        run_job(0, '1, "R5 zero", 0);
        // R6: overflow and exact fill
        run_job(200, '1, "R6 overflow", 0);
        run_job(128, '1, "R6 exactfill", 0);
        run_job(9, {96'h0, 32'h0000_0F0F}, "R6 sparse err", 0);
        // R2: start while busy ignored
        run_job(5, {32'h0, 32'hFF, 32'hF0, 32'h3C}, "R2 intrude", 1);
        drain();

        // R10: channel 2 -> lane 1 slot 0 for 4 and 8 channels
        al = {64'h0, 32'h0000_000F, 32'h0000_000F};
        run_job(4, al, "R10 4ch", 0);
        drain();
        check(lane_mask[32] == 1'b1 && lane_mask[2] == 1'b0, "R10", "4ch ch2 placement",
              lane_mask, MW'(64'h1_0000_0003));
        run_job(8, al, "R10 8ch", 0);
        drain();
        check(lane_mask[32] == 1'b1, "R10", "8ch ch2 placement", lane_mask, al);

        // R3/R4: irregular masks
        for (int t = 0; t < 24; t++) begin
            logic [MW-1:0] r;
            for (int l = 0; l < NL; l++) r[l*32 +: 32] = rnd32() & rnd32();
            run_job(int'(rnd32() % 80), r, "R4 random", (t % 5) == 2);
        end
        drain();

        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule